// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Registers

This block is the target-side configuration space of a simple PCI type-0 function. It takes the address and command that the bus front end has already latched, together with the active-low byte enables, the two data-phase handshake strobes and the write data. It returns the dword for a configuration read. Address and command capture, parity, and the generation of the target's own handshake are done elsewhere. The block only sees their results.

Most header dwords are fixed identification values set by parameters. Three locations hold state. The command half of dword 04h stores bits 10:0. Dword 10h is a base address register for a 4 KB, 32-bit, non-prefetchable memory window, and only bits 31:12 store data. Byte 0 of dword 3Ch is the interrupt line. A data phase completes only in a cycle where both the initiator-ready and target-ready strobes are low. That pair of strobes is the block's valid/ready handshake. The initiator holds write data stable while either strobe is high, and nothing is accepted until both are low. Read data is combinational, so it is already valid when the target signals ready.

Top module: `pci_cfg_header`

## Requirements
- R1: While `rst_n` is low, the command bits, the base address and the interrupt line all clear to zero.
- R2: A configuration read returns a fixed word for each of these offsets:
  - 00h: {device ID, vendor ID}
  - 08h: {class code, revision}
  - 0Ch: {BIST, header type, latency timer, cache line size}
  - 2Ch: {subsystem ID, subsystem vendor ID}
  - 3Ch bits 31:8: {max latency, min grant, interrupt pin}
- R3: State changes only at a clock edge where `lat_cmd` is 4'b1011 (configuration write), `irdy_n` is 0 and `trdy_n` is 0. Any other command code, or either strobe high, leaves every register unchanged.
- R4: Register selection compares only `lat_addr[7:0]` against the exact offset. Bits 31:8 have no effect on reads or writes.
- R5: The byte enables are active low. `be_n[i]` = 0 lets byte i (bits 8i+7:8i) of `wdata` be written. A lane whose enable is 1 keeps its old value.
- R6: Offset 10h reads bits 31:12 as the stored value and bits 11:0 as zero. Written values in bits 11:0 are dropped.
- R7: Offset 04h reads the status constant in bits 31:16 and the command word in bits 15:0. Only command bits 10:0 store data, and bits 15:11 read as zero. Writes to the status half are ignored.
- R8: At offset 3Ch only bits 7:0 (the interrupt line) store written data.
- R9: A write to any offset other than 04h, 10h and 3Ch changes no register.
- R10: `rdata` is zero unless `lat_cmd` is 4'b1010 (configuration read) and `irdy_n` is 0. During a read, every unlisted offset returns zero, including 14h–38h and 40h–FFh.
- R11: `rdata` reflects a completed write from the first cycle after the edge that stored it. There is no extra latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| lat_addr | input | 32 | Latched address of the current transaction |
| lat_cmd | input | 4 | Latched bus command code |
| be_n | input | 4 | Active-low byte enables of the data phase |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| wdata | input | 32 | Write data of the data phase |
| rdata | output | 32 | Configuration read data |

## Verification
A single completing write can exercise the byte-lane merge and the field masking in the same cycle. The bench sweeps all sixteen byte-enable patterns over the command word, the base address and the interrupt line. It writes data whose lanes differ, so that a lane leak and a masking error give different results. It judges each result by reading the register back against an arithmetic model. The write qualifier meeting a stalled handshake is also provoked: one strobe is held high while the write command and data are present. This is judged by a read-back showing that nothing moved.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
  localparam logic [3:0] CMD_CFG_READ  = 4'b1010;
  localparam logic [3:0] CMD_CFG_WRITE = 4'b1011;

  localparam logic [7:0] OFS_IDENT  = 8'h00;
  localparam logic [7:0] OFS_CMDSTS = 8'h04;
  localparam logic [7:0] OFS_CLASS  = 8'h08;
  localparam logic [7:0] OFS_MISC   = 8'h0C;
  localparam logic [7:0] OFS_BAR0   = 8'h10;
  localparam logic [7:0] OFS_SUBSYS = 8'h2C;
  localparam logic [7:0] OFS_IRQ    = 8'h3C;

  localparam int NUM_WTGT = 3;
  typedef enum logic [1:0] {
    WT_CMD  = 2'd0,
    WT_BAR  = 2'd1,
    WT_IRQ  = 2'd2
  } wtgt_e;
endpackage

// File: rtl/cfgh_decode.sv
module cfgh_decode
  import pcicfg_pkg::*;
(
  input  logic [7:0]          ofs,
  input  logic [3:0]          cmd,
  input  logic                irdy_n,
  input  logic                trdy_n,
  output logic [NUM_WTGT-1:0] wr_sel,
  output logic                rd_act
);
  logic wr_phase;

  assign wr_phase = (cmd == CMD_CFG_WRITE) && !irdy_n && !trdy_n;
  assign rd_act   = (cmd == CMD_CFG_READ) && !irdy_n;

  always_comb begin
    wr_sel = '0;
    if (wr_phase) begin
      unique case (ofs)
        OFS_CMDSTS: wr_sel[WT_CMD] = 1'b1;
        OFS_BAR0:   wr_sel[WT_BAR] = 1'b1;
        OFS_IRQ:    wr_sel[WT_IRQ] = 1'b1;
        default:    wr_sel = '0;
      endcase
    end
  end
endmodule

// File: rtl/cfgh_lanes.sv
module cfgh_lanes #(
  parameter int NBYTES = 4,
  parameter logic [8*NBYTES-1:0] WMASK = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [NBYTES-1:0]   be_n,
  input  logic [8*NBYTES-1:0] wdata,
  output logic [8*NBYTES-1:0] q
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[i*8 +: 8] <= 8'h00;
      else if (we && !be_n[i])
        q[i*8 +: 8] <= wdata[i*8 +: 8] & WMASK[i*8 +: 8];
    end

    p_lane_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (we && be_n[i]) |=> $stable(q[i*8 +: 8]));
  end
endmodule

// File: rtl/cfgh_rdmux.sv
module cfgh_rdmux
  import pcicfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID  = 16'h0C3D,
  parameter logic [23:0] CLASS_CODE = 24'h118000,
  parameter logic [7:0]  REV_ID     = 8'h02,
  parameter logic [7:0]  BIST_VAL   = 8'h00,
  parameter logic [7:0]  HDR_TYPE   = 8'h00,
  parameter logic [7:0]  LAT_TMR    = 8'h20,
  parameter logic [7:0]  CACHE_LS   = 8'h08,
  parameter logic [15:0] SUBSYS_VID = 16'h1A2B,
  parameter logic [15:0] SUBSYS_ID  = 16'h0001,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [7:0]  MIN_GNT    = 8'h03,
  parameter logic [7:0]  MAX_LAT    = 8'h05,
  parameter logic [15:0] STATUS_VAL = 16'h0200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_act,
  input  logic [7:0]  ofs,
  input  logic [15:0] cmd_word,
  input  logic [31:0] bar_word,
  input  logic [7:0]  irq_line,
  output logic [31:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd_act) begin
      case (ofs)
        OFS_IDENT:  rdata = {DEVICE_ID, VENDOR_ID};
        OFS_CMDSTS: rdata = {STATUS_VAL, cmd_word};
        OFS_CLASS:  rdata = {CLASS_CODE, REV_ID};
        OFS_MISC:   rdata = {BIST_VAL, HDR_TYPE, LAT_TMR, CACHE_LS};
        OFS_BAR0:   rdata = bar_word;
        OFS_SUBSYS: rdata = {SUBSYS_ID, SUBSYS_VID};
        OFS_IRQ:    rdata = {MAX_LAT, MIN_GNT, INT_PIN, irq_line};
        default:    rdata = '0;
      endcase
    end
  end

  p_bar_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && ofs == OFS_BAR0) |-> (rdata[11:0] == 12'h000));

  p_status_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && ofs == OFS_CMDSTS) |-> (rdata[31:16] == STATUS_VAL));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act |-> (rdata == 32'h0));
endmodule

// File: rtl/pci_cfg_header.sv
module pci_cfg_header
  import pcicfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID     = 16'h0C3D,
  parameter logic [23:0] CLASS_CODE    = 24'h118000,
  parameter logic [7:0]  REV_ID        = 8'h02,
  parameter logic [7:0]  BIST_VAL      = 8'h00,
  parameter logic [7:0]  HDR_TYPE      = 8'h00,
  parameter logic [7:0]  LAT_TMR       = 8'h20,
  parameter logic [7:0]  CACHE_LS      = 8'h08,
  parameter logic [15:0] SUBSYS_VID    = 16'h1A2B,
  parameter logic [15:0] SUBSYS_ID     = 16'h0001,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter logic [7:0]  MIN_GNT       = 8'h03,
  parameter logic [7:0]  MAX_LAT       = 8'h05,
  parameter logic [15:0] STATUS_VAL    = 16'h0200,
  parameter logic [15:0] CMD_WMASK     = 16'h07FF,
  parameter int          BAR_SIZE_LOG2 = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] lat_addr,
  input  logic [3:0]  lat_cmd,
  input  logic [3:0]  be_n,
  input  logic        irdy_n,
  input  logic        trdy_n,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  localparam logic [31:0] BAR_WMASK = ~((32'd1 << BAR_SIZE_LOG2) - 32'd1);

  logic [7:0]          ofs;
  logic [NUM_WTGT-1:0] wr_sel;
  logic                rd_act;
  logic [15:0]         cmd_word;
  logic [31:0]         bar_word;
  logic [7:0]          irq_line;
  logic                unused_hi;

  assign ofs       = lat_addr[7:0];
  assign unused_hi = ^lat_addr[31:8];

  cfgh_decode u_dec (
    .ofs    (ofs),
    .cmd    (lat_cmd),
    .irdy_n (irdy_n),
    .trdy_n (trdy_n),
    .wr_sel (wr_sel),
    .rd_act (rd_act)
  );

  cfgh_lanes #(.NBYTES(2), .WMASK(CMD_WMASK)) u_cmd (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_sel[WT_CMD]),
    .be_n  (be_n[1:0]),
    .wdata (wdata[15:0]),
    .q     (cmd_word)
  );

  cfgh_lanes #(.NBYTES(4), .WMASK(BAR_WMASK)) u_bar (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_sel[WT_BAR]),
    .be_n  (be_n),
    .wdata (wdata),
    .q     (bar_word)
  );

  cfgh_lanes #(.NBYTES(1), .WMASK(8'hFF)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_sel[WT_IRQ]),
    .be_n  (be_n[0:0]),
    .wdata (wdata[7:0]),
    .q     (irq_line)
  );

  cfgh_rdmux #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .CLASS_CODE(CLASS_CODE),
    .REV_ID(REV_ID), .BIST_VAL(BIST_VAL), .HDR_TYPE(HDR_TYPE),
    .LAT_TMR(LAT_TMR), .CACHE_LS(CACHE_LS), .SUBSYS_VID(SUBSYS_VID),
    .SUBSYS_ID(SUBSYS_ID), .INT_PIN(INT_PIN), .MIN_GNT(MIN_GNT),
    .MAX_LAT(MAX_LAT), .STATUS_VAL(STATUS_VAL)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_act   (rd_act),
    .ofs      (ofs),
    .cmd_word (cmd_word),
    .bar_word (bar_word),
    .irq_line (irq_line),
    .rdata    (rdata)
  );

  // R1: registers are clear on the edge after reset is seen low
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (cmd_word == 16'h0 && bar_word == 32'h0 && irq_line == 8'h0));

  p_no_handshake_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy_n || trdy_n || lat_cmd != CMD_CFG_WRITE)
    |=> ($stable(cmd_word) && $stable(bar_word) && $stable(irq_line)));

  p_other_ofs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && !trdy_n && lat_cmd == CMD_CFG_WRITE &&
     ofs != OFS_CMDSTS && ofs != OFS_BAR0 && ofs != OFS_IRQ)
    |=> ($stable(cmd_word) && $stable(bar_word) && $stable(irq_line)));

  p_wr_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));
endmodule

// File: tb/pci_cfg_header_test.sv
module pci_cfg_header_test;
  localparam logic [3:0] RD = 4'b1010;
  localparam logic [3:0] WR = 4'b1011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lat_addr = '0;
  logic [3:0]  lat_cmd = 4'h0;
  logic [3:0]  be_n = 4'hF;
  logic        irdy_n = 1'b1;
  logic        trdy_n = 1'b1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_cmd;
  logic [31:0] m_bar;
  logic [7:0]  m_irq;

  always #10 clk = ~clk;

  pci_cfg_header uut (
    .clk(clk), .rst_n(rst_n), .lat_addr(lat_addr), .lat_cmd(lat_cmd),
    .be_n(be_n), .irdy_n(irdy_n), .trdy_n(trdy_n), .wdata(wdata),
    .rdata(rdata)
  );

  function automatic logic [31:0] expect_rd(input logic [7:0] o);
    case (o)
      8'h00: return 32'h0C3D_1A2B;
      8'h04: return {16'h0200, m_cmd};
      8'h08: return 32'h1180_0002;
      8'h0C: return 32'h0000_2008;
      8'h10: return m_bar;
      8'h2C: return 32'h0001_1A2B;
      8'h3C: return {24'h05_03_01, m_irq};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] ben, input logic [31:0] msk);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++)
      if (!ben[b]) r[b*8 +: 8] = nw[b*8 +: 8] & msk[b*8 +: 8];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_wr(input logic [7:0] o, input logic [3:0] ben, input logic [31:0] d);
    if (o == 8'h04) m_cmd = merge({16'h0, m_cmd}, d, ben, 32'h0000_07FF) & 32'h07FF;
    else if (o == 8'h10) m_bar = merge(m_bar, d, ben, 32'hFFFF_F000);
    else if (o == 8'h3C) m_irq = merge({24'h0, m_irq}, d, ben, 32'h0000_00FF) & 32'hFF;
  endtask

  task automatic bus_wr(input logic [31:0] a, input logic [3:0] c, input logic [3:0] ben,
                        input logic [31:0] d, input logic ir, input logic tr);
    @(negedge clk);
    lat_addr = a; lat_cmd = c; be_n = ben; wdata = d; irdy_n = ir; trdy_n = tr;
    @(negedge clk);
    lat_cmd = 4'h0; irdy_n = 1'b1; trdy_n = 1'b1; be_n = 4'hF;
  endtask

  task automatic bus_rd(input logic [31:0] a, output logic [31:0] v);
    @(negedge clk);
    lat_addr = a; lat_cmd = RD; irdy_n = 1'b0; trdy_n = 1'b0;
    #1 v = rdata;
  endtask

  task automatic sweep(input string tag);
    logic [31:0] v;
    for (int o = 0; o < 256; o += 4) begin
      bus_rd({24'h0, o[7:0]}, v);
      chk($sformatf("%s ofs=%02h", tag, o), v, expect_rd(o[7:0]));
    end
  endtask

  initial begin
    logic [31:0] v;
    m_cmd = '0; m_bar = '0; m_irq = '0;
    repeat (3) @(negedge clk);
    chk("R10 idle rdata in reset", rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle rdata after reset", rdata, 32'h0);
    sweep("R1 R2 R10 reset sweep");

    // R6 R7 R8 R9: all-ones to every offset
    for (int o = 0; o < 256; o += 4) begin
      bus_wr({24'h0, o[7:0]}, WR, 4'h0, 32'hFFFF_FFFF, 1'b0, 1'b0);
      model_wr(o[7:0], 4'h0, 32'hFFFF_FFFF);
    end
    sweep("R6 R7 R8 R9 all-ones sweep");
    bus_rd(32'h10, v); chk("R6 bar mask", v, 32'hFFFF_F000);
    bus_rd(32'h04, v); chk("R7 cmd mask", v, 32'h0200_07FF);
    bus_rd(32'h3C, v); chk("R8 irq line", v, 32'h0503_01FF);

    // R5: every byte-enable pattern, lanes carry distinct data
    for (int p = 0; p < 16; p++) begin
      logic [31:0] d;
      d = {4'(p), 4'hA, 4'(~p), 4'h5, 4'(p+3), 4'hC, 4'(p*5), 4'h9};
      bus_wr(32'h04, WR, 4'(p), d, 1'b0, 1'b0); model_wr(8'h04, 4'(p), d);
      bus_wr(32'h10, WR, 4'(p), ~d, 1'b0, 1'b0); model_wr(8'h10, 4'(p), ~d);
      bus_wr(32'h3C, WR, 4'(p), d ^ 32'h5A, 1'b0, 1'b0); model_wr(8'h3C, 4'(p), d ^ 32'h5A);
      bus_rd(32'h04, v); chk($sformatf("R5 R7 cmd be=%h", p), v, expect_rd(8'h04));
      bus_rd(32'h10, v); chk($sformatf("R5 R6 bar be=%h", p), v, expect_rd(8'h10));
      bus_rd(32'h3C, v); chk($sformatf("R5 R8 irq be=%h", p), v, expect_rd(8'h3C));
    end

    // R3: stalled handshake and other commands do not write
    bus_wr(32'h10, WR, 4'h0, 32'h1234_5000, 1'b0, 1'b0); model_wr(8'h10, 4'h0, 32'h1234_5000);
    bus_wr(32'h10, WR, 4'h0, 32'hABCD_E000, 1'b0, 1'b1);
    bus_rd(32'h10, v); chk("R3 trdy high no write", v, 32'h1234_5000);
    bus_wr(32'h10, WR, 4'h0, 32'hABCD_E000, 1'b1, 1'b0);
    bus_rd(32'h10, v); chk("R3 irdy high no write", v, 32'h1234_5000);
    bus_wr(32'h10, WR, 4'h0, 32'hABCD_E000, 1'b1, 1'b1);
    bus_rd(32'h10, v); chk("R3 both high no write", v, 32'h1234_5000);
    for (int c = 0; c < 16; c++) begin
      if (c == 11) continue;
      bus_wr(32'h10, 4'(c), 4'h0, 32'hFFFF_FFFF, 1'b0, 1'b0);
      bus_wr(32'h04, 4'(c), 4'h0, 32'hFFFF_FFFF, 1'b0, 1'b0);
      bus_wr(32'h3C, 4'(c), 4'h0, 32'hFFFF_FFFF, 1'b0, 1'b0);
      bus_rd(32'h10, v); chk($sformatf("R3 cmd=%h bar", c), v, 32'h1234_5000);
      bus_rd(32'h04, v); chk($sformatf("R3 cmd=%h cmdword", c), v, expect_rd(8'h04));
      bus_rd(32'h3C, v); chk($sformatf("R3 cmd=%h irq", c), v, expect_rd(8'h3C));
    end

    // R4: upper address bits ignored
    bus_wr(32'hABCD_EF10, WR, 4'h0, 32'h8765_4321, 1'b0, 1'b0);
    model_wr(8'h10, 4'h0, 32'h8765_4321);
    bus_rd(32'h5500_0010, v); chk("R4 bar upper addr", v, 32'h8765_4000);
    bus_rd(32'hFFFF_FF00, v); chk("R4 ident upper addr", v, 32'h0C3D_1A2B);
    bus_rd(32'h0000_0140, v); chk("R4 R10 wrap 40h", v, 32'h0);

    // R11: visible on the first cycle after the storing edge
    @(negedge clk);
    lat_addr = 32'h3C; lat_cmd = WR; be_n = 4'hE; wdata = 32'h0000_0077;
    irdy_n = 1'b0; trdy_n = 1'b0;
    @(negedge clk);
    lat_cmd = RD; #1;
    chk("R11 immediate readback", rdata, 32'h0503_0177);
    m_irq = 8'h77;
    irdy_n = 1'b1; #1;
    chk("R10 read without irdy", rdata, 32'h0);

    // R1: reset mid-run clears state
    @(negedge clk); lat_cmd = 4'h0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_cmd = '0; m_bar = '0; m_irq = '0;
    sweep("R1 re-reset sweep");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule